// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block picks the pending interrupt line that is taken next and decides whether it may interrupt the handler that is already running. Each line has an 8-bit priority byte. Only its upper nibble counts, and a smaller nibble means more urgent. A group input splits that nibble. Its top bits form the preempt part and its remaining bits form the subpriority part. Only the preempt part decides whether one handler may nest inside another.

Requests arrive as one-cycle set pulses and are latched internally. Every cycle the most urgent latched request is found. Ordering is by the nibble, which compares the preempt part first and then the subpriority part, and then by the lowest line index. The request is taken only if its preempt level is strictly more urgent than the running level. Each take pushes the new running level onto an internal stack, and a return pulse pops it. A non-maskable request beats every line and nests over any handler except another non-maskable one.

Top module: `prio_nest_arb`

## Requirements
- R1: After reset, take_o is 0, run_lvl_o is 17 and no request is latched.
- R2: Only bits [7:4] of a line's priority byte are used, and the lower 4 bits have no effect. A smaller nibble is more urgent.
- R3: grp_i gives the number of preempt bits (0 to 4), and values 5 to 7 act as 4. The preempt value is the top grp_i bits of the nibble. The subpriority is the bits that remain.
- R4: run_lvl_o is 0 while a non-maskable handler runs, preempt+1 while a line handler runs, and 17 when no handler runs. At level 17 any latched request is taken.
- R5: A request is taken only when its preempt+1 is strictly below run_lvl_o. An equal preempt level never nests, even when the nibble is smaller.
- R6: Among latched lines with equal preempt value, the smallest subpriority wins, whatever the line indices.
- R7: Lines with equal nibbles are served in order of lowest index first.
- R8: A request latched at one clock edge is taken at the next edge if it is allowed. take_o is high for one cycle with take_id_o set to the line number, and the line's latch is cleared, so one pulse gives exactly one take.
- R9: A ret_i pulse pops the stack. run_lvl_o returns to the level below, or to 17. No take happens in that cycle. ret_i while idle has no effect.
- R10: nmi_set_i latches a non-maskable request. It is taken with take_id_o = NUM_IRQ over any line handler and sets run_lvl_o to 0. While a non-maskable handler runs, a new one stays latched until the return.
- R11: All NUM_IRQ lines (81 by default) can be served, including the last one, 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set_i | input | NUM_IRQ | One-cycle request pulses, one per line |
| prio_i | input | NUM_IRQ*8 | Priority bytes, line n at bits [8n+7:8n] |
| grp_i | input | 3 | Number of preempt bits in the nibble |
| nmi_set_i | input | 1 | Non-maskable request pulse |
| ret_i | input | 1 | Handler return pulse (pops the stack) |
| take_o | output | 1 | One-cycle take strobe |
| take_id_o | output | clog2(NUM_IRQ+1) | Line taken; NUM_IRQ marks the non-maskable request |
| run_lvl_o | output | 5 | Running level (0 NMI, preempt+1, 17 idle) |

## Verification
The bench targets equal-preempt pairs whose nibbles differ under a coarse group setting. A design that nests on the full nibble would take the second request at once instead of holding it until the return. It also checks a lower-index line against a higher-index line with a better subpriority, and two equal nibbles. Swapped tie-breaks would deliver the wrong line first. A non-maskable request is raised twice in a row, where a design that drops or re-nests the second one shows up at the return. Group values above 4, the last line index and returns while idle are covered, along with the lower priority nibble that must have no effect.

// File: rtl/nest_arb_pkg.sv
package nest_arb_pkg;
    localparam int          KEY_W    = 4;
    localparam int          LVL_W    = 5;
    localparam logic [4:0]  LVL_NMI  = 5'd0;
    localparam logic [4:0]  LVL_IDLE = 5'd17;

    // preempt part: top (grp, clamped to 4) bits of the nibble
    function automatic logic [KEY_W-1:0] preempt_of(input logic [KEY_W-1:0] key,
                                                    input logic [2:0] grp);
        logic [2:0] pb;
        pb = (grp > 3'd4) ? 3'd4 : grp;
        return key >> (3'd4 - pb);
    endfunction
endpackage

// File: rtl/prio_split.sv
module prio_split #(
    parameter int NUM_IRQ = 81
) (
    input  logic [NUM_IRQ*8-1:0]                       prio_i,
    output logic [NUM_IRQ-1:0][nest_arb_pkg::KEY_W-1:0] key_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign key_o[g] = prio_i[g*8+4 +: nest_arb_pkg::KEY_W];
    end
endmodule

// File: rtl/pick_winner.sv
module pick_winner #(
    parameter int NUM_IRQ = 81,
    parameter int ID_W    = 7
) (
    input  logic [NUM_IRQ-1:0]                          req_i,
    input  logic [NUM_IRQ-1:0][nest_arb_pkg::KEY_W-1:0] key_i,
    output logic                                        found_o,
    output logic [ID_W-1:0]                             id_o,
    output logic [nest_arb_pkg::KEY_W-1:0]              key_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        key_o   = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req_i[i] && (!found_o || key_i[i] < key_o)) begin
                found_o = 1'b1;
                key_o   = key_i[i];
                id_o    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_nest_arb.sv
module prio_nest_arb
    import nest_arb_pkg::*;
#(
    parameter int NUM_IRQ     = 81,
    parameter int STACK_DEPTH = 17,
    localparam int ID_W       = $clog2(NUM_IRQ + 1),
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IRQ-1:0]    irq_set_i,
    input  logic [NUM_IRQ*8-1:0]  prio_i,
    input  logic [2:0]            grp_i,
    input  logic                  nmi_set_i,
    input  logic                  ret_i,
    output logic                  take_o,
    output logic [ID_W-1:0]       take_id_o,
    output logic [LVL_W-1:0]      run_lvl_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0]                  pend;
        logic                                nmi_pend;
        logic [STACK_DEPTH-1:0][LVL_W-1:0]   stk;
        logic [SP_W-1:0]                     sp;
        logic                                take;
        logic [ID_W-1:0]                     id;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_IRQ-1:0][KEY_W-1:0] key;
    logic                          win_found;
    logic [ID_W-1:0]               win_id;
    logic [KEY_W-1:0]              win_key;
    logic [LVL_W-1:0]              win_lvl;
    logic [LVL_W-1:0]              cur_lvl;
    logic                          stack_full;

    prio_split #(.NUM_IRQ(NUM_IRQ)) u_split (
        .prio_i (prio_i),
        .key_o  (key)
    );

    pick_winner #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_pick (
        .req_i   (st_q.pend),
        .key_i   (key),
        .found_o (win_found),
        .id_o    (win_id),
        .key_o   (win_key)
    );

    always_comb begin
        cur_lvl    = (st_q.sp == '0) ? LVL_IDLE : st_q.stk[st_q.sp - 1'b1];
        win_lvl    = LVL_W'(preempt_of(win_key, grp_i)) + 5'd1;
        stack_full = (st_q.sp == SP_W'(STACK_DEPTH));

        st_d      = st_q;
        st_d.take = 1'b0;

        if (ret_i) begin
            if (st_q.sp != '0) begin
                st_d.sp = st_q.sp - 1'b1;
            end
        end else if (!stack_full) begin
            if (st_q.nmi_pend && cur_lvl != LVL_NMI) begin
                st_d.take          = 1'b1;
                st_d.id            = ID_W'(NUM_IRQ);
                st_d.nmi_pend      = 1'b0;
                st_d.stk[st_q.sp]  = LVL_NMI;
                st_d.sp            = st_q.sp + 1'b1;
            end else if (win_found && win_lvl < cur_lvl) begin
                st_d.take          = 1'b1;
                st_d.id            = win_id;
                st_d.pend[win_id]  = 1'b0;
                st_d.stk[st_q.sp]  = win_lvl;
                st_d.sp            = st_q.sp + 1'b1;
            end
        end

        st_d.pend     = st_d.pend | irq_set_i;
        st_d.nmi_pend = st_d.nmi_pend | nmi_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o    = st_q.take;
    assign take_id_o = st_q.id;
    assign run_lvl_o = cur_lvl;
endmodule

// File: rtl/nest_arb_chk.sv
module nest_arb_chk #(
    parameter int NUM_IRQ = 81,
    parameter int ID_W    = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_i,
    input logic            take_o,
    input logic [ID_W-1:0] take_id_o,
    input logic [4:0]      run_lvl_o
);
    // R5
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> run_lvl_o < $past(run_lvl_o));

    // R9
    ret_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> !take_o);

    // R9
    ret_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && run_lvl_o != 5'd17) |=> run_lvl_o > $past(run_lvl_o));

    // R9
    idle_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && run_lvl_o == 5'd17) |=> run_lvl_o == 5'd17);

    // R10
    nmi_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_id_o == ID_W'(NUM_IRQ)) |-> run_lvl_o == 5'd0);

    // R4
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_lvl_o <= 5'd17);

    // R8
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> take_id_o <= ID_W'(NUM_IRQ));
endmodule

bind prio_nest_arb nest_arb_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_i     (ret_i),
    .take_o    (take_o),
    .take_id_o (take_id_o),
    .run_lvl_o (run_lvl_o)
);

// File: tb/prio_nest_arb_tb.sv
module prio_nest_arb_tb;
    localparam int N    = 81;
    localparam int ID_W = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    irq_set;
    logic [N*8-1:0]  prio;
    logic [2:0]      grp;
    logic            nmi_set;
    logic            ret;
    logic            take;
    logic [ID_W-1:0] take_id;
    logic [4:0]      run_lvl;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prio_nest_arb #(.NUM_IRQ(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_set_i (irq_set),
        .prio_i    (prio),
        .grp_i     (grp),
        .nmi_set_i (nmi_set),
        .ret_i     (ret),
        .take_o    (take),
        .take_id_o (take_id),
        .run_lvl_o (run_lvl)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] g);
        rst_n = 1'b0; irq_set = '0; nmi_set = 1'b0; ret = 1'b0;
        prio = '0; grp = g;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input int line);
        irq_set = '0;
        irq_set[line] = 1'b1;
        @(negedge clk);
        irq_set = '0;
    endtask

    task automatic pulse2(input int a, input int b);
        irq_set = '0;
        irq_set[a] = 1'b1;
        irq_set[b] = 1'b1;
        @(negedge clk);
        irq_set = '0;
    endtask

    task automatic pulse_nmi();
        nmi_set = 1'b1;
        @(negedge clk);
        nmi_set = 1'b0;
    endtask

    task automatic do_ret();
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
    endtask

    // expect a take at the coming edge
    task automatic exp_take(input string tag, input int id, input int lvl);
        @(negedge clk);
        chk({tag, " take strobe"}, int'(take), 1);
        chk({tag, " take id"}, int'(take_id), id);
        chk({tag, " running level"}, int'(run_lvl), lvl);
    endtask

    task automatic exp_none(input string tag, input int lvl, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk({tag, " no take"}, int'(take), 0);
            chk({tag, " level held"}, int'(run_lvl), lvl);
        end
    endtask

    task automatic t_reset();
        do_reset(3'd4);
        chk("R1 level after reset", int'(run_lvl), 17);
        exp_none("R1", 17, 3);
    endtask

    task automatic t_field_and_order();
        do_reset(3'd4);
        prio[5*8 +: 8] = 8'h2F;
        prio[3*8 +: 8] = 8'h30;
        pulse2(5, 3);
        exp_take("R2 upper nibble decides", 5, 3);
        @(negedge clk);
        chk("R8 strobe one cycle", int'(take), 0);
        exp_none("R5 less urgent waits", 3, 2);
        do_ret();
        chk("R9 back to idle", int'(run_lvl), 17);
        exp_take("R4 idle takes any", 3, 4);
        do_ret();
        exp_none("R8 latch cleared", 17, 3);
    endtask

    task automatic t_nesting();
        do_reset(3'd4);
        prio[10*8 +: 8] = 8'h60;
        prio[11*8 +: 8] = 8'h40;
        prio[12*8 +: 8] = 8'h30;
        pulse(10);
        exp_take("R5 first", 10, 7);
        pulse(11);
        exp_take("R5 strict nest", 11, 5);
        do_ret();
        chk("R9 pop to previous", int'(run_lvl), 7);
        do_ret();
        chk("R9 pop to idle", int'(run_lvl), 17);

        do_reset(3'd2);
        prio[10*8 +: 8] = 8'h60;
        prio[11*8 +: 8] = 8'h40;
        prio[12*8 +: 8] = 8'h30;
        pulse(10);
        exp_take("R3 grp2 first", 10, 2);
        pulse(11);
        exp_none("R5 equal preempt no nest", 2, 2);
        pulse(12);
        exp_take("R3 grp2 lower preempt nests", 12, 1);
        do_ret();
        chk("R9 pop level", int'(run_lvl), 2);
        exp_none("R5 still equal", 2, 1);
        do_ret();
        exp_take("R9 pending served after return", 11, 2);
        do_ret();
        do_ret();
        chk("R9 return while idle", int'(run_lvl), 17);
    endtask

    task automatic t_ties();
        do_reset(3'd2);
        prio[2*8 +: 8] = 8'h70;
        prio[9*8 +: 8] = 8'h40;
        pulse2(2, 9);
        exp_take("R6 subpriority beats index", 9, 2);
        do_ret();
        exp_take("R6 second", 2, 2);
        do_ret();

        do_reset(3'd3);
        prio[7*8 +: 8]  = 8'h90;
        prio[20*8 +: 8] = 8'h90;
        pulse2(20, 7);
        exp_take("R7 lowest index first", 7, 5);
        do_ret();
        exp_take("R7 next index", 20, 5);
        do_ret();
    endtask

    task automatic t_groups();
        do_reset(3'd0);
        prio[1*8 +: 8] = 8'hF0;
        prio[0*8 +: 8] = 8'h00;
        pulse(1);
        exp_take("R3 grp0 single level", 1, 1);
        pulse(0);
        exp_none("R3 grp0 never nests", 1, 2);

        do_reset(3'd7);
        prio[1*8 +: 8] = 8'hF0;
        prio[0*8 +: 8] = 8'h00;
        pulse(1);
        exp_take("R3 grp7 acts as 4", 1, 16);
        pulse(0);
        exp_take("R3 grp7 nests", 0, 1);
    endtask

    task automatic t_nmi();
        do_reset(3'd4);
        prio[4*8 +: 8] = 8'h00;
        pulse(4);
        exp_take("R10 base handler", 4, 1);
        pulse_nmi();
        exp_take("R10 nmi nests", N, 0);
        pulse_nmi();
        exp_none("R10 nmi in nmi", 0, 2);
        do_ret();
        chk("R10 pop to line level", int'(run_lvl), 1);
        exp_take("R10 latched nmi served", N, 0);
        do_ret();
        do_ret();
        chk("R10 back idle", int'(run_lvl), 17);
    endtask

    task automatic t_last_line();
        do_reset(3'd4);
        prio[80*8 +: 8] = 8'h1C;
        pulse(80);
        exp_take("R11 last line", 80, 2);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_field_and_order();
        t_nesting();
        t_ties();
        t_groups();
        t_nmi();
        t_last_line();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule